// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 interrupt source lines and presents them to a processor as two request outputs: a normal request and a fast request. Each request has its own bank of registers. A bank holds an enable mask, a 4-bit priority threshold, a masked and a raw status view, a current-source register and an acknowledge register. The two banks share three kinds of per-source setting: a polarity select, a latch select and a 4-bit priority. Routing a source to the normal or the fast output is done by enabling it in the matching bank.

Software enables sources with write-one-to-set and write-one-to-clear registers. On a request, the handler reads the current-source register to get the winning index. Reading the acknowledge register releases the winning latched source. The register bus is a plain 32-bit strobe interface. Read data is registered and becomes valid in the cycle after the read strobe.

Top module: `vic_ctrl`

## Requirements
- R1: After reset both requests are low, all enables and priorities are 0, both thresholds are 0xF, latch select is all zeros and polarity select is all ones.
- R2: Each bank has an enable-set register at offset 0x08 and an enable-clear register at offset 0x0C. A 1 bit written to enable-set enables that source, and a 1 bit written to enable-clear disables it. Zero bits change nothing. Reading 0x08 returns the enable mask, and reading 0x0C returns 0.
- R3: Raw status (offset 0x04) shows the pending vector of every source, whatever the enables are.
- R4: Masked status (offset 0x00) is pending AND enabled AND passing the threshold. A bank's request output is high exactly when its masked status is nonzero. The two banks act independently.
- R5: Current source (offset 0x20) returns the index of the masked-status source with the smallest priority value. A tie goes to the lower index. With nothing masked it returns 32.
- R6: The threshold (offset 0x2C, bits 3:0) lets a source through when its priority value is less than or equal to the threshold.
- R7: Polarity select sits at 0x200. A 1 bit takes the source line as it is, and a 0 bit inverts it.
- R8: Latch select sits at 0x204. With a 0 bit, the source's pending state follows the conditioned line. With a 1 bit, a rising edge of the conditioned line sets a pending latch. The latch holds until that source is the current winner of a bank whose acknowledge register (offset 0x28) is read. The acknowledge read returns the current-source value.
- R9: The priority of source i is bits 3:0 of the word at 0x300 + 4*i, and it reads back.
- R10: The normal bank is at 0x000 and the fast bank at 0x100, with the same layout. Read data appears the cycle after the read strobe and holds otherwise. Writes to status, current and acknowledge offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source lines |
| addr_i | input | 10 | Byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal request |
| fiq_o | output | 1 | Fast request |

## Verification
The main function is exercised with random source, polarity, enable, threshold and priority patterns, which tell apart mistakes in masking, threshold comparison and arbitration order. Directed patterns cover the rest. Equal priorities on two sources separate the tie-break direction. A threshold set to 0 leaves the block with no winner, which exposes the empty-current code. An inverted-polarity idle line tells polarity handling apart from enable handling. A single-cycle pulse on a latched source shows edge capture and the release by acknowledge, as distinct from level following.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NSRC   = 32;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned ADDR_W = 10;

  localparam logic [7:0] OFF_MSTAT = 8'h00;
  localparam logic [7:0] OFF_RAW   = 8'h04;
  localparam logic [7:0] OFF_ENSET = 8'h08;
  localparam logic [7:0] OFF_ENCLR = 8'h0C;
  localparam logic [7:0] OFF_CUR   = 8'h20;
  localparam logic [7:0] OFF_ACK   = 8'h28;
  localparam logic [7:0] OFF_THR   = 8'h2C;

  localparam logic [ADDR_W-1:0] A_INV    = 10'h200;
  localparam logic [ADDR_W-1:0] A_STICKY = 10'h204;
  localparam logic [2:0]        A_PRIO_HI = 3'b110;
endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] inv_sel_i,
  input  logic [N-1:0] sticky_sel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] cond, prev_q, latch_q;

  // polarity bit 1 = pass through, 0 = invert
  assign cond = ~(src_i ^ inv_sel_i);

  for (genvar g = 0; g < N; g++) begin : g_src
    logic rise;
    assign rise = cond[g] & ~prev_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g]  <= 1'b0;
        latch_q[g] <= 1'b0;
      end else begin
        prev_q[g]  <= cond[g];
        latch_q[g] <= sticky_sel_i[g] & (rise | (latch_q[g] & ~clr_i[g]));
      end
    end

    assign pend_o[g] = sticky_sel_i[g] ? latch_q[g] : cond[g];

    p_edge_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_sel_i[g] && rise) |=> (latch_q[g] || !sticky_sel_i[g]));
    p_sticky_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_sel_i[g] && latch_q[g] && !clr_i[g]) |=> (latch_q[g] || !sticky_sel_i[g]));
  end
endmodule

// File: rtl/vic_bank.sv
module vic_bank #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         pend_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  input  logic                 set_we_i,
  input  logic                 clr_we_i,
  input  logic                 thr_we_i,
  input  logic [N-1:0]         wdata_i,
  input  logic                 ack_i,
  output logic [N-1:0]         en_o,
  output logic [PW-1:0]        thr_o,
  output logic [N-1:0]         masked_o,
  output logic [IW-1:0]        cur_o,
  output logic                 req_o,
  output logic [N-1:0]         clr_o
);
  logic [N-1:0]  en_q, pass;
  logic [PW-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= '1;
    end else begin
      if (set_we_i) en_q <= en_q | wdata_i;
      if (clr_we_i) en_q <= en_q & ~wdata_i;
      if (thr_we_i) thr_q <= wdata_i[PW-1:0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pass
    assign pass[g]  = prio_i[g] <= thr_q;
    assign clr_o[g] = ack_i && req_o && (cur_o == IW'(g));
  end

  assign masked_o = pend_i & en_q & pass;
  assign req_o    = |masked_o;
  assign en_o     = en_q;
  assign thr_o    = thr_q;

  // strict compare keeps the lower index on equal priority
  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    found = 1'b0;
    best  = '1;
    cur_o = IW'(N);
    for (int i = 0; i < N; i++) begin
      if (masked_o[i] && (!found || prio_i[i] < best)) begin
        found = 1'b1;
        best  = prio_i[i];
        cur_o = IW'(i);
      end
    end
  end

  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  p_en_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((en_q & $past(wdata_i)) == '0));
  p_thr_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> (thr_q == $past(wdata_i[PW-1:0])));
  p_req_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((pend_i & en_q) != '0));
  p_cur_pick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (cur_o < IW'(N) && masked_o[cur_o[IW-2:0]]));
  p_cur_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (cur_o == IW'(N)));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned IW = $clog2(NSRC) + 1;
  localparam int unsigned PI = $clog2(NSRC);

  logic [NSRC-1:0]             inv_q, sticky_q, pend, clr_any;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [1:0][NSRC-1:0]        en, masked, clr;
  logic [1:0][IW-1:0]          cur;
  logic [1:0][PRIO_W-1:0]      thr;
  logic [1:0]                  req;
  logic [7:0]                  off;
  logic                        in_bank, in_prio;
  logic [PI-1:0]               pidx;
  logic [31:0]                 rd_val;

  assign off     = addr_i[7:0];
  assign in_bank = ~addr_i[9];
  assign in_prio = (addr_i[9:7] == A_PRIO_HI) && (addr_i[1:0] == 2'b00);
  assign pidx    = addr_i[PI+1:2];

  vic_src_cond #(.N(NSRC)) u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .inv_sel_i(inv_q),
    .sticky_sel_i(sticky_q), .clr_i(clr_any), .pend_o(pend)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic hit;
    assign hit = wr_i && in_bank && (addr_i[8] == b[0]);
    vic_bank #(.N(NSRC), .PW(PRIO_W)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .prio_i(prio_q),
      .set_we_i(hit && off == OFF_ENSET),
      .clr_we_i(hit && off == OFF_ENCLR),
      .thr_we_i(hit && off == OFF_THR),
      .wdata_i(wdata_i[NSRC-1:0]),
      .ack_i(rd_i && in_bank && (addr_i[8] == b[0]) && off == OFF_ACK),
      .en_o(en[b]), .thr_o(thr[b]), .masked_o(masked[b]), .cur_o(cur[b]),
      .req_o(req[b]), .clr_o(clr[b])
    );
  end

  assign clr_any = clr[0] | clr[1];
  assign irq_o   = req[0];
  assign fiq_o   = req[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q    <= '1;
      sticky_q <= '0;
      prio_q   <= '0;
    end else if (wr_i) begin
      if (addr_i == A_INV)    inv_q    <= wdata_i[NSRC-1:0];
      if (addr_i == A_STICKY) sticky_q <= wdata_i[NSRC-1:0];
      if (in_prio)            prio_q[pidx] <= wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_bank) begin
      case (off)
        OFF_MSTAT:        rd_val = masked[addr_i[8]];
        OFF_RAW:          rd_val = pend;
        OFF_ENSET:        rd_val = en[addr_i[8]];
        OFF_CUR, OFF_ACK: rd_val = 32'(cur[addr_i[8]]);
        OFF_THR:          rd_val = 32'(thr[addr_i[8]]);
        default:          rd_val = '0;
      endcase
    end else if (addr_i == A_INV) begin
      rd_val = inv_q;
    end else if (addr_i == A_STICKY) begin
      rd_val = sticky_q;
    end else if (in_prio) begin
      rd_val = 32'(prio_q[pidx]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_prio_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_prio) |=> (prio_q[$past(pidx)] == $past(wdata_i[PRIO_W-1:0])));
  p_inv_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_INV) |=> (inv_q == $past(wdata_i)));
endmodule

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src = '0;
  logic [9:0]  addr = '0;
  logic        wr = 0, rd = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_chk = 0, n_err = 0;
  logic [3:0] prio_m [32];

  always #10 clk = ~clk;

  vic_ctrl u_vic_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic set_prio(input int i, input logic [3:0] p);
    bus_wr(10'h300 + 10'(4 * i), 32'(p));
    prio_m[i] = p;
  endtask

  function automatic logic [31:0] m_masked(logic [31:0] pend, logic [31:0] en, logic [3:0] thr);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = pend[i] & en[i] & (prio_m[i] <= thr);
    return m;
  endfunction

  function automatic logic [31:0] m_cur(logic [31:0] msk);
    logic [31:0] c = 32;
    logic [3:0]  best = '1;
    for (int i = 0; i < 32; i++)
      if (msk[i] && (c == 32 || prio_m[i] < best)) begin c = i; best = prio_m[i]; end
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d, inv, en0, en1, pend, m0, m1;
    logic [3:0]  t0, t1;
    void'($urandom(32'd20131204));
    for (int i = 0; i < 32; i++) prio_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 fiq", 32'(fiq), 0);
    bus_rd(10'h008, d); check("R1 en0", d, 0);
    bus_rd(10'h108, d); check("R1 en1", d, 0);
    bus_rd(10'h02C, d); check("R1 thr0", d, 32'hF);
    bus_rd(10'h200, d); check("R1 inv", d, 32'hFFFF_FFFF);
    bus_rd(10'h204, d); check("R1 sticky", d, 0);
    bus_rd(10'h314, d); check("R1 prio5", d, 0);
    bus_rd(10'h020, d); check("R1 R5 cur idle", d, 32);

    // random level-mode patterns: R3 R4 R5 R6 R7 R9
    for (int it = 0; it < 30; it++) begin
      src = $urandom; inv = $urandom; en0 = $urandom; en1 = $urandom;
      t0 = 4'($urandom); t1 = 4'($urandom);
      bus_wr(10'h200, inv);
      bus_wr(10'h00C, 32'hFFFF_FFFF); bus_wr(10'h008, en0);
      bus_wr(10'h10C, 32'hFFFF_FFFF); bus_wr(10'h108, en1);
      bus_wr(10'h02C, 32'(t0)); bus_wr(10'h12C, 32'(t1));
      for (int i = 0; i < 32; i++) set_prio(i, 4'($urandom));
      pend = ~(src ^ inv);
      m0 = m_masked(pend, en0, t0);
      m1 = m_masked(pend, en1, t1);
      check("R4 irq", 32'(irq), 32'(m0 != 0));
      check("R4 fiq", 32'(fiq), 32'(m1 != 0));
      bus_rd(10'h004, d); check("R3 R7 raw", d, pend);
      bus_rd(10'h000, d); check("R4 R6 masked0", d, m0);
      bus_rd(10'h100, d); check("R4 R6 masked1", d, m1);
      bus_rd(10'h020, d); check("R5 cur0", d, m_cur(m0));
      bus_rd(10'h120, d); check("R5 cur1", d, m_cur(m1));
      bus_rd(10'h300 + 10'(4 * (it % 32)), d); check("R9 prio", d, 32'(prio_m[it % 32]));
    end

    // R2 set/clear semantics
    bus_wr(10'h00C, 32'hFFFF_FFFF);
    bus_wr(10'h008, 32'h0000_000F);
    bus_wr(10'h00C, 32'h0000_0005);
    bus_rd(10'h008, d); check("R2 en after set/clr", d, 32'h0000_000A);
    bus_wr(10'h008, 32'h0);
    bus_rd(10'h008, d); check("R2 zero set keeps", d, 32'h0000_000A);
    bus_rd(10'h00C, d); check("R2 clr reads 0", d, 0);

    // R10 writes to read-only offsets ignored
    bus_wr(10'h004, 32'hFFFF_FFFF);
    bus_wr(10'h020, 32'hFFFF_FFFF);
    bus_rd(10'h008, d); check("R10 en unchanged", d, 32'h0000_000A);

    // R7 inversion on idle line
    src = 0;
    bus_wr(10'h200, 32'h0);
    bus_rd(10'h004, d); check("R7 inverted idle", d, 32'hFFFF_FFFF);
    bus_wr(10'h200, 32'hFFFF_FFFF);
    bus_rd(10'h004, d); check("R7 direct idle", d, 0);

    // R5 tie break and R6 threshold
    bus_wr(10'h00C, 32'hFFFF_FFFF); bus_wr(10'h10C, 32'hFFFF_FFFF);
    bus_wr(10'h02C, 32'hF);
    for (int i = 0; i < 32; i++) set_prio(i, 4'd0);
    bus_wr(10'h008, 32'h0000_0280);
    src = 32'h0000_0280;
    bus_rd(10'h020, d); check("R5 tie lower index", d, 7);
    set_prio(7, 4'd2); set_prio(9, 4'd1);
    bus_rd(10'h020, d); check("R5 lower value wins", d, 9);
    check("R10 fiq independent", 32'(fiq), 0);
    bus_wr(10'h02C, 32'h1);
    bus_rd(10'h000, d); check("R6 thr blocks 7", d, 32'h0000_0200);
    bus_wr(10'h02C, 32'h0);
    bus_rd(10'h020, d); check("R6 R5 none passes", d, 32);
    check("R4 R6 irq low", 32'(irq), 0);

    // R8 sticky latch and acknowledge
    src = 0;
    bus_wr(10'h02C, 32'hF);
    bus_wr(10'h00C, 32'hFFFF_FFFF);
    bus_wr(10'h204, 32'h0000_0008);
    bus_wr(10'h008, 32'h0000_0008);
    @(negedge clk); src[3] = 1;
    @(negedge clk); src[3] = 0;
    @(negedge clk);
    check("R8 latched irq", 32'(irq), 1);
    bus_rd(10'h004, d); check("R8 raw latched", d & 32'h8, 32'h8);
    bus_rd(10'h028, d); check("R8 ack returns cur", d, 3);
    check("R8 irq after ack", 32'(irq), 0);
    bus_rd(10'h004, d); check("R8 raw cleared", d & 32'h8, 0);
    bus_wr(10'h204, 32'h0);
    src[3] = 1;
    @(negedge clk);
    check("R8 level follows", 32'(irq), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule